// File: doc/BRIEF.md
# Indirect Register Access Port

This block is a small host-facing I/O window that gives access to two internal register banks through one shared index register. The host first stores an 8-bit index into the pointer register. It then reads or writes one of two data ports. One port reaches the control/status bank and the other reaches the configuration bank. Both ports use the same index, so the pointer does not need to be reloaded when moving from one bank to the other.

Two I/O address layouts are supported: a word layout and a doubleword layout. A static strap input selects the layout. It is captured while reset is held and is ignored after that. The pointer and the configuration data port move to different offsets in the doubleword layout. The control/status port keeps the same offset in both layouts.

Accesses complete in one cycle. A read returns data in the cycle the access is acknowledged. A write takes effect at the next clock edge. Indices with no register behind them read as zero, and writes to them are dropped. Offsets outside the map behave the same way.

Top module: `ioreg_window`

## Requirements
- R1: After hardware reset, the pointer reads 0 and every register in both banks reads 0.
- R2: In word layout (strap 0), the pointer is at offset 12h, the control/status port at 10h and the configuration port at 16h.
- R3: In doubleword layout (strap 1), the pointer is at offset 14h, the control/status port at 10h and the configuration port at 1Ch.
- R4: A pointer write stores write-data bits 7..0. A pointer read returns the index in bits 7..0 and zero in bits 31..8.
- R5: The same index selects the register for both data ports. Index n on the control/status port and index n on the configuration port address two independent registers.
- R6: A data-port read or write never changes the pointer, and the pointer does not auto-increment.
- R7: An index at or above the bank depth (8 control/status registers, 6 configuration registers) reads as 0. A write through it changes no register.
- R8: A read of an offset outside the map for the current layout returns 0. A write to such an offset changes neither the pointer nor any register.
- R9: A pulse on the software clear input sets the pointer to 0 at the next edge and leaves the bank contents unchanged.
- R10: io_ack is high exactly in the cycles where io_sel is high. Read data is valid in that same cycle, and a written value can be read back in the next access.
- R11: The layout strap is sampled only during reset. Changing it afterwards does not move the offsets.
- R12: Registers are 16 bits wide. Write-data bits 31..16 are dropped on bank writes, and bank reads return zero in bits 31..16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| dword_strap | input | 1 | Layout strap: 0 selects word layout, 1 selects doubleword layout; sampled during reset |
| soft_clr | input | 1 | Synchronous software reset of the pointer |
| io_sel | input | 1 | Access request for this cycle |
| io_wr | input | 1 | 1 for write, 0 for read |
| io_addr | input | 5 | Byte offset within the I/O window |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, valid while io_ack is high |
| io_ack | output | 1 | Access acknowledge |

## Verification
A corrupted pointer is the most visible fault. Every data-port access that follows it lands on the wrong register, so the next read of either bank returns a value that does not match. The pointer can also be read back directly in one cycle. A wrong captured layout shows on the first access: the pointer or configuration port then answers at the other layout's offset, and the correct offset reads zero. A bank write that leaks into a neighbouring register or into an undefined index shows only when that register is read back later. For that reason the bench rereads earlier registers after every corner-case write.

// File: rtl/ioreg_pkg.sv
package ioreg_pkg;

  // Target selected by an I/O offset
  typedef enum logic [1:0] {
    PORT_NONE = 2'd0,
    PORT_PTR  = 2'd1,
    PORT_CSR  = 2'd2,
    PORT_CFG  = 2'd3
  } port_e;

  // Offsets shared by both layouts or specific to one
  localparam int OFS_CSR   = 'h10;
  localparam int OFS_PTR_W = 'h12;
  localparam int OFS_CFG_W = 'h16;
  localparam int OFS_PTR_D = 'h14;
  localparam int OFS_CFG_D = 'h1C;

endpackage

// File: rtl/ioreg_decode.sv
module ioreg_decode
  import ioreg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              dword_mode,
  input  logic [ADDR_W-1:0] addr,
  output port_e             target
);

  localparam logic [ADDR_W-1:0] A_CSR   = ADDR_W'(OFS_CSR);
  localparam logic [ADDR_W-1:0] A_PTR_W = ADDR_W'(OFS_PTR_W);
  localparam logic [ADDR_W-1:0] A_CFG_W = ADDR_W'(OFS_CFG_W);
  localparam logic [ADDR_W-1:0] A_PTR_D = ADDR_W'(OFS_PTR_D);
  localparam logic [ADDR_W-1:0] A_CFG_D = ADDR_W'(OFS_CFG_D);

  logic [ADDR_W-1:0] ptr_ofs;
  logic [ADDR_W-1:0] cfg_ofs;

  always_comb begin
    ptr_ofs = dword_mode ? A_PTR_D : A_PTR_W;
    cfg_ofs = dword_mode ? A_CFG_D : A_CFG_W;
    if (addr == A_CSR) begin
      target = PORT_CSR;
    end else if (addr == ptr_ofs) begin
      target = PORT_PTR;
    end else if (addr == cfg_ofs) begin
      target = PORT_CFG;
    end else begin
      target = PORT_NONE;
    end
  end

endmodule

// File: rtl/ioreg_bank.sv
module ioreg_bank #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [IDX_W:0] DEPTH_L = (IDX_W+1)'(DEPTH);

  logic              in_range;
  logic [DATA_W-1:0] regs_q [DEPTH];

  assign in_range = ({1'b0, idx} < DEPTH_L);

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic              hit;
    logic              en;
    logic [DATA_W-1:0] d;

    always_comb begin
      hit = in_range && (idx == IDX_W'(g));
      en  = wr_en && hit;
      d   = en ? wdata : regs_q[g];
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= '0;
      end else if (en) begin
        regs_q[g] <= d;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (in_range && (idx == IDX_W'(i))) begin
        rdata = regs_q[i];
      end
    end
  end

endmodule

// File: rtl/ioreg_window.sv
module ioreg_window
  import ioreg_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int BUS_W     = 32,
  parameter int DATA_W    = 16,
  parameter int IDX_W     = 8,
  parameter int CSR_DEPTH = 8,
  parameter int CFG_DEPTH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dword_strap,
  input  logic              soft_clr,
  input  logic              io_sel,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [BUS_W-1:0]  io_wdata,
  output logic [BUS_W-1:0]  io_rdata,
  output logic              io_ack
);

  localparam int PTR_PAD = BUS_W - IDX_W;
  localparam int DAT_PAD = BUS_W - DATA_W;

  // Reset synchronizer: asynchronous assert, synchronous release
  logic rst_meta_q;
  logic rst_ni_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q  <= 1'b0;
      rst_ni_sync <= 1'b0;
    end else begin
      rst_meta_q  <= 1'b1;
      rst_ni_sync <= rst_meta_q;
    end
  end

  // Layout strap, loaded only while reset is held
  logic mode_q;

  always_ff @(posedge clk) begin
    if (!rst_ni_sync) begin
      mode_q <= dword_strap;
    end
  end

  // Offset decode
  port_e target;

  ioreg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .dword_mode (mode_q),
    .addr       (io_addr),
    .target     (target)
  );

  logic rd_go;
  logic wr_go;
  logic ptr_we;
  logic csr_we;
  logic cfg_we;

  always_comb begin
    wr_go  = io_sel && io_wr;
    rd_go  = io_sel && !io_wr;
    ptr_we = wr_go && (target == PORT_PTR);
    csr_we = wr_go && (target == PORT_CSR);
    cfg_we = wr_go && (target == PORT_CFG);
  end

  // Pointer register: next state then register
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = soft_clr || ptr_we;
    if (soft_clr) begin
      ptr_d = '0;
    end else if (ptr_we) begin
      ptr_d = io_wdata[IDX_W-1:0];
    end else begin
      ptr_d = ptr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni_sync) begin
    if (!rst_ni_sync) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  // Register banks
  logic [DATA_W-1:0] csr_rdata;
  logic [DATA_W-1:0] cfg_rdata;

  ioreg_bank #(
    .DEPTH  (CSR_DEPTH),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_csr_bank (
    .clk    (clk),
    .rst_ni (rst_ni_sync),
    .wr_en  (csr_we),
    .idx    (ptr_q),
    .wdata  (io_wdata[DATA_W-1:0]),
    .rdata  (csr_rdata)
  );

  ioreg_bank #(
    .DEPTH  (CFG_DEPTH),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_cfg_bank (
    .clk    (clk),
    .rst_ni (rst_ni_sync),
    .wr_en  (cfg_we),
    .idx    (ptr_q),
    .wdata  (io_wdata[DATA_W-1:0]),
    .rdata  (cfg_rdata)
  );

  // Read mux
  always_comb begin
    io_rdata = '0;
    if (rd_go) begin
      unique case (target)
        PORT_PTR: io_rdata = {{PTR_PAD{1'b0}}, ptr_q};
        PORT_CSR: io_rdata = {{DAT_PAD{1'b0}}, csr_rdata};
        PORT_CFG: io_rdata = {{DAT_PAD{1'b0}}, cfg_rdata};
        default:  io_rdata = '0;
      endcase
    end
  end

  assign io_ack = io_sel;

endmodule

// File: rtl/ioreg_window_chk.sv
module ioreg_window_chk #(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 32,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              mode_q,
  input logic              soft_clr,
  input logic              io_sel,
  input logic              io_wr,
  input logic [ADDR_W-1:0] io_addr,
  input logic [BUS_W-1:0]  io_wdata,
  input logic [BUS_W-1:0]  io_rdata,
  input logic [IDX_W-1:0]  ptr_q
);

  logic [ADDR_W-1:0] ptr_at;
  logic [ADDR_W-1:0] cfg_at;
  logic              at_ptr;
  logic              mapped;

  always_comb begin
    ptr_at = mode_q ? ADDR_W'('h14) : ADDR_W'('h12);
    cfg_at = mode_q ? ADDR_W'('h1C) : ADDR_W'('h16);
    at_ptr = (io_addr == ptr_at);
    mapped = at_ptr || (io_addr == cfg_at) || (io_addr == ADDR_W'('h10));
  end

  // R6: the pointer changes only on a pointer write or a software clear
  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    !(io_sel && io_wr && at_ptr) && !soft_clr |=> $stable(ptr_q));

  // R4: a pointer write loads the low index bits
  assert_ptr_load_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    io_sel && io_wr && at_ptr && !soft_clr |=> ptr_q == $past(io_wdata[IDX_W-1:0]));

  // R4: a pointer read shows the index with zero upper bits
  assert_ptr_read_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    io_sel && !io_wr && at_ptr |-> io_rdata == {{(BUS_W-IDX_W){1'b0}}, ptr_q});

  // R9: a software clear zeroes the pointer
  assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    soft_clr |=> ptr_q == '0);

  // R8: an unmapped offset reads as zero
  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    io_sel && !io_wr && !mapped |-> io_rdata == '0);

  // R11: the layout stays fixed while out of reset
  assert_mode_fixed_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    rst_ni |=> $stable(mode_q));

endmodule

bind ioreg_window ioreg_window_chk #(
  .ADDR_W (ADDR_W),
  .BUS_W  (BUS_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk      (clk),
  .rst_ni   (rst_ni_sync),
  .mode_q   (mode_q),
  .soft_clr (soft_clr),
  .io_sel   (io_sel),
  .io_wr    (io_wr),
  .io_addr  (io_addr),
  .io_wdata (io_wdata),
  .io_rdata (io_rdata),
  .ptr_q    (ptr_q)
);

// File: tb/ioreg_window_tb.sv
`timescale 1ns/1ps
module ioreg_window_tb;

  logic        clk;
  logic        rst_n;
  logic        dword_strap;
  logic        soft_clr;
  logic        io_sel;
  logic        io_wr;
  logic [4:0]  io_addr;
  logic [31:0] io_wdata;
  logic [31:0] io_rdata;
  logic        io_ack;

  int checks;
  int errors;
  bit done;

  ioreg_window u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .dword_strap (dword_strap),
    .soft_clr    (soft_clr),
    .io_sel      (io_sel),
    .io_wr       (io_wr),
    .io_addr     (io_addr),
    .io_wdata    (io_wdata),
    .io_rdata    (io_rdata),
    .io_ack      (io_ack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [4:0]  addr;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  // Word layout sequence, run right after reset
  localparam int NVEC = 20;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 5'h12, 32'h0,         32'h0},     // R1 pointer after reset
    '{1'b1, 5'h12, 32'hFFFF_FF03, 32'h0},     // R2 R4 pointer write
    '{1'b0, 5'h12, 32'h0,         32'h3},     // R4 low byte only
    '{1'b1, 5'h10, 32'h0000_1234, 32'h0},     // R2 control/status port
    '{1'b1, 5'h16, 32'h0000_ABCD, 32'h0},     // R2 configuration port
    '{1'b0, 5'h10, 32'h0,         32'h1234},  // R5
    '{1'b0, 5'h16, 32'h0,         32'hABCD},  // R5 independent banks
    '{1'b0, 5'h12, 32'h0,         32'h3},     // R6 no auto-increment
    '{1'b1, 5'h12, 32'h0000_0004, 32'h0},
    '{1'b0, 5'h10, 32'h0,         32'h0},     // R1 bank cleared by reset
    '{1'b1, 5'h10, 32'hFFFF_5555, 32'h0},     // R12 upper bits dropped
    '{1'b0, 5'h10, 32'h0,         32'h5555},  // R12
    '{1'b1, 5'h12, 32'h0000_0040, 32'h0},     // R7 undefined index
    '{1'b1, 5'h10, 32'h0000_7777, 32'h0},     // R7 write discarded
    '{1'b0, 5'h10, 32'h0,         32'h0},     // R7 reads zero
    '{1'b1, 5'h14, 32'h0000_0001, 32'h0},     // R8 unmapped in word layout
    '{1'b0, 5'h14, 32'h0,         32'h0},     // R8
    '{1'b0, 5'h12, 32'h0,         32'h40},    // R8 pointer untouched
    '{1'b1, 5'h12, 32'h0000_0003, 32'h0},
    '{1'b0, 5'h10, 32'h0,         32'h1234}   // R7 R8 bank intact
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [4:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic ack);
    @(negedge clk);
    io_sel   = 1'b1;
    io_wr    = wr;
    io_addr  = a;
    io_wdata = d;
    #5;
    rd  = io_rdata;
    ack = io_ack;
    @(negedge clk);
    io_sel = 1'b0;
    io_wr  = 1'b0;
  endtask

  task automatic hard_reset(input logic strap);
    dword_strap = strap;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    logic        ack;
    checks = 0; errors = 0; done = 0;
    io_sel = 0; io_wr = 0; io_addr = '0; io_wdata = '0; soft_clr = 0;
    hard_reset(1'b0);

    // R10: no acknowledge while idle
    #3;
    check("R10 idle ack", {31'b0, io_ack}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      access(VECS[i].wr, VECS[i].addr, VECS[i].wd, rd, ack);
      check($sformatf("R10 ack vec%0d", i), {31'b0, ack}, 32'h1);
      if (!VECS[i].wr) check($sformatf("vector %0d", i), rd, VECS[i].exp);
    end

    // R11: strap change after reset has no effect
    dword_strap = 1'b1;
    access(1'b0, 5'h12, 32'h0, rd, ack);
    check("R11 word pointer offset kept", rd, 32'h3);
    access(1'b0, 5'h14, 32'h0, rd, ack);
    check("R11 dword offset still unmapped", rd, 32'h0);

    // R9: software clear zeroes pointer, keeps banks
    @(negedge clk); soft_clr = 1'b1;
    @(negedge clk); soft_clr = 1'b0;
    access(1'b0, 5'h12, 32'h0, rd, ack);
    check("R9 pointer cleared", rd, 32'h0);
    access(1'b1, 5'h12, 32'h3, rd, ack);
    access(1'b0, 5'h10, 32'h0, rd, ack);
    check("R9 bank kept", rd, 32'h1234);

    // R7: configuration bank depth 6, index 6 undefined
    access(1'b1, 5'h12, 32'h6, rd, ack);
    access(1'b1, 5'h16, 32'h0000_9999, rd, ack);
    access(1'b0, 5'h16, 32'h0, rd, ack);
    check("R7 cfg index 6 reads zero", rd, 32'h0);
    access(1'b1, 5'h12, 32'h5, rd, ack);
    access(1'b1, 5'h16, 32'h0000_2222, rd, ack);
    access(1'b0, 5'h16, 32'h0, rd, ack);
    check("R7 cfg index 5 defined", rd, 32'h2222);

    // R3: doubleword layout after a new hard reset
    hard_reset(1'b1);
    access(1'b0, 5'h14, 32'h0, rd, ack);
    check("R1 pointer after second reset", rd, 32'h0);
    access(1'b1, 5'h14, 32'h2, rd, ack);
    access(1'b1, 5'h10, 32'h0000_AAAA, rd, ack);
    access(1'b1, 5'h1C, 32'h0000_BBBB, rd, ack);
    access(1'b0, 5'h10, 32'h0, rd, ack);
    check("R3 csr port", rd, 32'hAAAA);
    access(1'b0, 5'h1C, 32'h0, rd, ack);
    check("R3 cfg port", rd, 32'hBBBB);
    access(1'b0, 5'h14, 32'h0, rd, ack);
    check("R3 pointer offset", rd, 32'h2);
    access(1'b0, 5'h12, 32'h0, rd, ack);
    check("R3 word pointer offset unmapped", rd, 32'h0);
    access(1'b0, 5'h16, 32'h0, rd, ack);
    check("R3 word cfg offset unmapped", rd, 32'h0);
    access(1'b1, 5'h14, 32'h3, rd, ack);
    access(1'b0, 5'h10, 32'h0, rd, ack);
    check("R1 bank cleared by second reset", rd, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule